// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This block screens every instruction fetch and data access against eight programmable address windows. Each window holds a base address, a power-of-two size, an enable bit, two 2-bit permission codes (one for fetches, one for data), and cacheable and bufferable attributes. For each access the unit finds the matching window with the highest index. It checks the access type and privilege against that window's permission code. One cycle later it reports an abort flag, the cacheable and bufferable attributes, and the index of the winning window.

A single global enable turns checking on. While it is clear, nothing aborts and every access is reported as non-cacheable and non-bufferable. While it is set, an address that hits no enabled window is always aborted. Software that wants a permissive default programs window 0 with the largest size code, so that it spans the whole 4 GB space and catches every address the other windows miss.

Top module: `mpu_region_guard`

## Requirements
- R1: In every cycle that follows a clock edge with `rst` high, all response outputs are 0. Reset also clears every window enable and the global enable.
- R2: The response is registered. `rsp_valid` equals the `acc_valid` of the previous cycle. When that bit was 0, `rsp_abort`, `rsp_cache`, `rsp_buf`, `rsp_hit` and `rsp_region` are all 0.
- R3: When the global enable is clear, an access gets `rsp_abort`=0, `rsp_cache`=0, `rsp_buf`=0 and `rsp_hit`=0, whatever the windows hold.
- R4: When the global enable is set and the address lies in no enabled window, `rsp_abort`=1, `rsp_hit`=0, `rsp_region`=0, and both attributes are 0.
- R5: A window with size code N spans 2^(N+1) bytes. Address bits below N+1 are ignored in both the access address and the programmed base, so the base is always aligned to the size. Size codes below 11 behave as 11 (4 KB).
- R6: Size code 31 makes a window match every 32-bit address.
- R7: When several enabled windows match, the one with the highest index wins. `rsp_region` shows that index and the attributes come from it.
- R8: A fetch (`acc_instr`=1) is checked against the window's fetch permission and is always treated as a read, whatever `acc_write` is. A data access is checked against the data permission.
- R9: Permission codes: 00 denies all access; 01 allows privileged read and write only; 10 allows privileged read and write plus user read; 11 allows everything. A denied access gives `rsp_abort`=1 with both attributes 0. An allowed access gives `rsp_abort`=0 and passes the window's cacheable and bufferable bits through.
- R10: A window whose enable bit is 0 never matches.
- R11: A window write with `cfg_we`=1 takes effect at the clock edge. An access presented in the same cycle is judged with the old contents, and an access in the next cycle sees the new contents.
- R12: With `ctl_we`=1, the global enable takes the value of `ctl_enable` at the clock edge. With `ctl_we`=0, the global enable holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one window record |
| cfg_idx | input | 3 | Index of the window to write |
| cfg_base | input | 32 | Window base address (low bits ignored) |
| cfg_size | input | 5 | Size code N, span 2^(N+1) bytes |
| cfg_en | input | 1 | Window enable |
| cfg_iperm | input | 2 | Fetch permission code |
| cfg_dperm | input | 2 | Data permission code |
| cfg_cache | input | 1 | Cacheable attribute |
| cfg_buf | input | 1 | Bufferable attribute |
| ctl_we | input | 1 | Write strobe for the global enable |
| ctl_enable | input | 1 | New global enable value |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_write | input | 1 | 1 = data write |
| acc_priv | input | 1 | 1 = privileged mode |
| rsp_valid | output | 1 | Registered response valid |
| rsp_abort | output | 1 | Access aborted |
| rsp_cache | output | 1 | Cacheable attribute of the allowed access |
| rsp_buf | output | 1 | Bufferable attribute of the allowed access |
| rsp_hit | output | 1 | Some enabled window matched while checking was on |
| rsp_region | output | 3 | Index of the winning window |

## Verification
The assertions assume that `rst` is held high for at least one edge before any check counts. They also assume that every control and access input is a settled 0 or 1 at each edge. The bench drives every input only at falling edges, keeps `rst` high for several cycles at the start, and never leaves a strobe undefined. The bench's random phase programs windows with arbitrary, often unaligned bases and arbitrary size codes. It aims addresses both inside and just outside those windows, so overlaps, misses and every permission code occur. It never relies on anything beyond the 2-bit codes and 5-bit size field defined above.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned SIZE_W = 5;

  typedef enum logic [1:0] {
    PERM_NONE    = 2'b00,
    PERM_PRIV    = 2'b01,
    PERM_USER_RD = 2'b10,
    PERM_ALL     = 2'b11
  } perm_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [SIZE_W-1:0] code;
    logic              en;
    logic [1:0]        iperm;
    logic [1:0]        dperm;
    logic              cache;
    logic              buff;
  } window_t;

  function automatic logic perm_grants(input logic [1:0] code, input logic wr, input logic priv);
    case (perm_e'(code))
      PERM_NONE:    perm_grants = 1'b0;
      PERM_PRIV:    perm_grants = priv;
      PERM_USER_RD: perm_grants = priv | ~wr;
      default:      perm_grants = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/mpu_window_bank.sv
module mpu_window_bank import mpu_pkg::*; #(
  parameter int NUM_WIN = 8,
  parameter int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [IDX_W-1:0]                cfg_idx,
  input  window_t                         cfg_rec,
  input  logic                            ctl_we,
  input  logic                            ctl_enable,
  output logic                            glob_en,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  base_o,
  output logic [NUM_WIN-1:0][SIZE_W-1:0]  code_o,
  output logic [NUM_WIN-1:0]              en_o,
  output logic [NUM_WIN-1:0][1:0]         iperm_o,
  output logic [NUM_WIN-1:0][1:0]         dperm_o,
  output logic [NUM_WIN-1:0]              cache_o,
  output logic [NUM_WIN-1:0]              buf_o
);
  window_t win_q [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        win_q[g] <= '0;
      end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
        win_q[g] <= cfg_rec;
      end
    end
    assign base_o[g]  = win_q[g].base;
    assign code_o[g]  = win_q[g].code;
    assign en_o[g]    = win_q[g].en;
    assign iperm_o[g] = win_q[g].iperm;
    assign dperm_o[g] = win_q[g].dperm;
    assign cache_o[g] = win_q[g].cache;
    assign buf_o[g]   = win_q[g].buff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en <= 1'b0;
    end else if (ctl_we) begin
      glob_en <= ctl_enable;
    end
  end

  assert_cfg_write_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (en_o[$past(cfg_idx)] == $past(cfg_rec.en)) && (base_o[$past(cfg_idx)] == $past(cfg_rec.base)));
  assert_ctl_write_R12: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> glob_en == $past(ctl_enable));
  assert_ctl_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |=> $stable(glob_en));
endmodule

// File: rtl/mpu_window_match.sv
module mpu_window_match import mpu_pkg::*; #(
  parameter int NUM_WIN  = 8,
  parameter int MIN_CODE = 11
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  base_i,
  input  logic [NUM_WIN-1:0][SIZE_W-1:0]  code_i,
  input  logic [NUM_WIN-1:0]              en_i,
  output logic [NUM_WIN-1:0]              hit_vec
);
  localparam logic [SIZE_W-1:0] MIN_C = SIZE_W'(MIN_CODE);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    logic [SIZE_W-1:0] eff_code;
    logic [ADDR_W:0]   span;
    logic [ADDR_W:0]   low_ones;
    logic [ADDR_W-1:0] keep;
    always_comb begin
      eff_code = (code_i[g] < MIN_C) ? MIN_C : code_i[g];
      span     = (ADDR_W+1)'(1) << ({1'b0, eff_code} + 6'd1);
      low_ones = span - (ADDR_W+1)'(1);
      keep     = ~low_ones[ADDR_W-1:0];
      hit_vec[g] = en_i[g] && ((addr & keep) == (base_i[g] & keep));
    end
  end
endmodule

// File: rtl/mpu_top_pick.sv
module mpu_top_pick #(
  parameter int NUM_WIN = 8,
  parameter int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] hit_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx
);
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mpu_region_guard.sv
module mpu_region_guard import mpu_pkg::*; #(
  parameter int NUM_WIN  = 8,
  parameter int MIN_CODE = 11,
  parameter int IDX_W    = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_base,
  input  logic [4:0]        cfg_size,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_iperm,
  input  logic [1:0]        cfg_dperm,
  input  logic              cfg_cache,
  input  logic              cfg_buf,
  input  logic              ctl_we,
  input  logic              ctl_enable,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  input  logic              acc_instr,
  input  logic              acc_write,
  input  logic              acc_priv,
  output logic              rsp_valid,
  output logic              rsp_abort,
  output logic              rsp_cache,
  output logic              rsp_buf,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_region
);
  window_t                        cfg_rec;
  logic                           glob_en;
  logic [NUM_WIN-1:0][ADDR_W-1:0] w_base;
  logic [NUM_WIN-1:0][SIZE_W-1:0] w_code;
  logic [NUM_WIN-1:0]             w_en, w_cache, w_buf, hit_vec;
  logic [NUM_WIN-1:0][1:0]        w_iperm, w_dperm;
  logic                           any_hit;
  logic [IDX_W-1:0]               win_idx;
  logic [1:0]                     perm_sel;
  logic                           granted;

  assign cfg_rec = '{base: cfg_base, code: cfg_size, en: cfg_en, iperm: cfg_iperm,
                     dperm: cfg_dperm, cache: cfg_cache, buff: cfg_buf};

  mpu_window_bank #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_rec(cfg_rec),
    .ctl_we(ctl_we), .ctl_enable(ctl_enable), .glob_en(glob_en),
    .base_o(w_base), .code_o(w_code), .en_o(w_en), .iperm_o(w_iperm),
    .dperm_o(w_dperm), .cache_o(w_cache), .buf_o(w_buf)
  );

  mpu_window_match #(.NUM_WIN(NUM_WIN), .MIN_CODE(MIN_CODE)) u_match (
    .addr(acc_addr), .base_i(w_base), .code_i(w_code), .en_i(w_en), .hit_vec(hit_vec)
  );

  mpu_top_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_pick (
    .hit_vec(hit_vec), .any_hit(any_hit), .win_idx(win_idx)
  );

  // Fetches use the fetch code and are always reads.
  assign perm_sel = acc_instr ? w_iperm[win_idx] : w_dperm[win_idx];
  assign granted  = any_hit && perm_grants(perm_sel, acc_write & ~acc_instr, acc_priv);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_abort  <= 1'b0;
      rsp_cache  <= 1'b0;
      rsp_buf    <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
    end else begin
      rsp_valid <= acc_valid;
      if (acc_valid && glob_en) begin
        rsp_abort  <= ~granted;
        rsp_cache  <= granted & w_cache[win_idx];
        rsp_buf    <= granted & w_buf[win_idx];
        rsp_hit    <= any_hit;
        rsp_region <= any_hit ? win_idx : '0;
      end else begin
        rsp_abort  <= 1'b0;
        rsp_cache  <= 1'b0;
        rsp_buf    <= 1'b0;
        rsp_hit    <= 1'b0;
        rsp_region <= '0;
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid && !rsp_abort && !rsp_hit);
  assert_resp_valid_R2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !rsp_valid && !rsp_abort && !rsp_cache && !rsp_buf);
  assert_disabled_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !glob_en) |=> !rsp_abort && !rsp_cache && !rsp_buf && !rsp_hit);
  assert_miss_abort_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && glob_en && hit_vec == '0) |=> rsp_abort && !rsp_hit);
  assert_winner_hits_R7: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> hit_vec[win_idx] && (hit_vec >> win_idx) == NUM_WIN'(1));
  assert_abort_no_attr_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && glob_en && any_hit && !granted) |=> rsp_abort && !rsp_cache && !rsp_buf);
endmodule

// File: tb/mpu_region_guard_test.sv
`timescale 1ns/1ps
module mpu_region_guard_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic        cfg_we, cfg_en, cfg_cache, cfg_buf, ctl_we, ctl_enable;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_base, acc_addr;
  logic [4:0]  cfg_size;
  logic [1:0]  cfg_iperm, cfg_dperm;
  logic        acc_valid, acc_instr, acc_write, acc_priv;
  logic        rsp_valid, rsp_abort, rsp_cache, rsp_buf, rsp_hit;
  logic [2:0]  rsp_region;

  mpu_region_guard uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_en(cfg_en), .cfg_iperm(cfg_iperm), .cfg_dperm(cfg_dperm),
    .cfg_cache(cfg_cache), .cfg_buf(cfg_buf), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_instr(acc_instr),
    .acc_write(acc_write), .acc_priv(acc_priv), .rsp_valid(rsp_valid),
    .rsp_abort(rsp_abort), .rsp_cache(rsp_cache), .rsp_buf(rsp_buf),
    .rsp_hit(rsp_hit), .rsp_region(rsp_region)
  );

  int checks = 0;
  int errors = 0;

  // Reference state
  logic [31:0] m_base [8];
  int          m_code [8];
  bit          m_en [8], m_c [8], m_b [8];
  bit   [1:0]  m_ip [8], m_dp [8];
  bit          m_glob;
  bit   [7:0]  expv;

  function automatic bit in_window(int k, logic [31:0] a);
    int n = (m_code[k] < 11) ? 11 : m_code[k];
    if (n >= 31) return 1'b1;
    return (a >> (n + 1)) == (m_base[k] >> (n + 1));
  endfunction

  function automatic bit allowed(bit [1:0] p, bit wr, bit pv);
    if (p == 2'b00) return 1'b0;
    if (p == 2'b01) return pv;
    if (p == 2'b10) return pv || !wr;
    return 1'b1;
  endfunction

  // Expected response bits: {valid, abort, cache, buf, hit, region[2:0]}
  function automatic bit [7:0] predict();
    int w = -1;
    bit ok;
    if (!acc_valid) return 8'h00;
    if (!m_glob) return 8'h80;
    for (int k = 7; k >= 0; k--) begin
      if (w < 0 && m_en[k] && in_window(k, acc_addr)) w = k;
    end
    if (w < 0) return 8'hC0;
    ok = allowed(acc_instr ? m_ip[w] : m_dp[w], acc_write && !acc_instr, acc_priv);
    return {1'b1, !ok, ok && m_c[w], ok && m_b[w], 1'b1, 3'(w)};
  endfunction

  task automatic cyc(string tag);
    @(posedge clk);
    if (rst) begin
      expv = 8'h00;
      m_glob = 1'b0;
      for (int k = 0; k < 8; k++) begin
        m_en[k] = 1'b0; m_base[k] = '0; m_code[k] = 0; m_ip[k] = 0; m_dp[k] = 0;
        m_c[k] = 0; m_b[k] = 0;
      end
    end else begin
      expv = predict();
      if (cfg_we) begin
        m_base[cfg_idx] = cfg_base; m_code[cfg_idx] = int'(cfg_size); m_en[cfg_idx] = cfg_en;
        m_ip[cfg_idx] = cfg_iperm; m_dp[cfg_idx] = cfg_dperm;
        m_c[cfg_idx] = cfg_cache; m_b[cfg_idx] = cfg_buf;
      end
      if (ctl_we) m_glob = ctl_enable;
    end
    @(negedge clk);
    checks++;
    if ({rsp_valid, rsp_abort, rsp_cache, rsp_buf, rsp_hit, rsp_region} !== expv) begin
      errors++;
      $display("FAIL %s: got v%0b a%0b c%0b b%0b h%0b r%0d expected v%0b a%0b c%0b b%0b h%0b r%0d",
               tag, rsp_valid, rsp_abort, rsp_cache, rsp_buf, rsp_hit, rsp_region,
               expv[7], expv[6], expv[5], expv[4], expv[3], expv[2:0]);
    end
    cfg_we = 0; ctl_we = 0; acc_valid = 0;
  endtask

  task automatic set_win(int k, logic [31:0] b, int n, bit en, bit [1:0] ip, bit [1:0] dp,
                         bit c, bit bf, string tag);
    cfg_we = 1; cfg_idx = 3'(k); cfg_base = b; cfg_size = 5'(n); cfg_en = en;
    cfg_iperm = ip; cfg_dperm = dp; cfg_cache = c; cfg_buf = bf;
    cyc(tag);
  endtask

  task automatic set_glob(bit v, string tag);
    ctl_we = 1; ctl_enable = v;
    cyc(tag);
  endtask

  task automatic access(logic [31:0] a, bit ins, bit wr, bit pv, string tag);
    acc_valid = 1; acc_addr = a; acc_instr = ins; acc_write = wr; acc_priv = pv;
    cyc(tag);   // registers the access
    cyc(tag);   // response visible in this window
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; cfg_we = 0; cfg_idx = 0; cfg_base = 0; cfg_size = 0; cfg_en = 0;
    cfg_iperm = 0; cfg_dperm = 0; cfg_cache = 0; cfg_buf = 0; ctl_we = 0; ctl_enable = 0;
    acc_valid = 0; acc_addr = 0; acc_instr = 0; acc_write = 0; acc_priv = 0;
    repeat (4) cyc("R1");
    rst = 0;
    cyc("R1");
    // Unit off: no abort even with no windows
    access(32'h1234_5678, 0, 1, 0, "R3");
    set_glob(1'b0, "R12");
    access(32'h0000_0010, 1, 0, 0, "R12");
    set_glob(1'b1, "R12");
    access(32'h0000_0010, 0, 0, 1, "R4");
    cyc("R2");
    // Background window
    set_win(0, 32'hDEAD_BEEF, 31, 1, 2'b11, 2'b11, 1, 0, "R6");
    access(32'hFFFF_FFFC, 0, 1, 0, "R6");
    access(32'h0000_0000, 1, 0, 0, "R6");
    // 64 KB window, unaligned base
    set_win(2, 32'h2000_1234, 15, 1, 2'b00, 2'b01, 1, 1, "R5");
    access(32'h2000_FFFC, 0, 0, 1, "R5");
    access(32'h2001_0000, 0, 0, 1, "R5");
    access(32'h1FFF_FFFC, 0, 0, 1, "R5");
    // Overlap: 4 KB window at higher index, lower index also overlapping
    set_win(5, 32'h2000_8000, 11, 1, 2'b11, 2'b10, 0, 1, "R7");
    set_win(1, 32'h2000_8000, 12, 1, 2'b11, 2'b11, 1, 1, "R7");
    access(32'h2000_8010, 0, 0, 0, "R7");
    access(32'h2000_9010, 0, 0, 0, "R7");
    // Permissions on window 5 (data code 10)
    access(32'h2000_8020, 0, 1, 0, "R9");
    access(32'h2000_8020, 0, 1, 1, "R9");
    set_win(5, 32'h2000_8000, 11, 1, 2'b11, 2'b01, 1, 1, "R9");
    access(32'h2000_8020, 0, 0, 0, "R9");
    access(32'h2000_8020, 0, 0, 1, "R9");
    set_win(5, 32'h2000_8000, 11, 1, 2'b11, 2'b00, 1, 1, "R9");
    access(32'h2000_8020, 0, 0, 1, "R9");
    // Fetch uses its own code and ignores write
    access(32'h2000_8020, 1, 1, 0, "R8");
    set_win(5, 32'h2000_8000, 11, 1, 2'b10, 2'b11, 1, 1, "R8");
    access(32'h2000_8020, 1, 1, 0, "R8");
    // Disabled window never matches
    set_win(5, 32'h2000_8000, 11, 0, 2'b11, 2'b11, 1, 1, "R10");
    set_win(1, 32'h2000_8000, 12, 0, 2'b11, 2'b11, 1, 1, "R10");
    access(32'h2000_8020, 0, 0, 1, "R10");
    // Write and access in the same cycle
    cfg_we = 1; cfg_idx = 3'd7; cfg_base = 32'h4000_0000; cfg_size = 5'd3; cfg_en = 1;
    cfg_iperm = 2'b11; cfg_dperm = 2'b00; cfg_cache = 1; cfg_buf = 1;
    acc_valid = 1; acc_addr = 32'h4000_0004; acc_instr = 0; acc_write = 0; acc_priv = 1;
    cyc("R11");
    cyc("R11");
    access(32'h4000_0004, 0, 0, 1, "R11");
    access(32'h4000_0FFC, 0, 0, 1, "R5");
    access(32'h4000_1000, 0, 0, 1, "R5");
    // Remove background: plain miss
    set_win(0, 32'h0, 31, 0, 2'b11, 2'b11, 1, 1, "R4");
    access(32'h8000_0000, 0, 0, 1, "R4");
    set_glob(1'b0, "R3");
    access(32'h4000_0004, 0, 0, 1, "R3");
    set_glob(1'b1, "R12");
    // Random traffic
    for (int t = 0; t < 6000; t++) begin
      int r = int'($urandom_range(0, 9));
      if (r == 0) begin
        cfg_we = 1; cfg_idx = 3'($urandom); cfg_base = $urandom;
        cfg_size = ($urandom_range(0, 7) == 0) ? 5'd31 : 5'($urandom_range(0, 20));
        cfg_en = ($urandom_range(0, 3) != 0); cfg_iperm = 2'($urandom); cfg_dperm = 2'($urandom);
        cfg_cache = 1'($urandom); cfg_buf = 1'($urandom);
      end else if (r == 1 && $urandom_range(0, 15) == 0) begin
        ctl_we = 1; ctl_enable = ($urandom_range(0, 3) != 0);
      end
      acc_valid = ($urandom_range(0, 4) != 0);
      acc_addr = m_base[$urandom_range(0, 7)] ^ ($urandom & ((32'd1 << $urandom_range(4, 22)) - 1));
      if ($urandom_range(0, 9) == 0) acc_addr = $urandom;
      acc_instr = 1'($urandom); acc_write = 1'($urandom); acc_priv = 1'($urandom);
      cyc("R9");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule